// File: doc/BRIEF.md
# Host Control Reset/Shutdown Timer

This block sits in a battery protection controller and interprets an active-high control level driven by the host. While the level is held high past a short debounce window, both the charge and the discharge switch enables are pulled low. How long the level stays high decides what happens next. A short press turns the switches back on when it ends, which gives the host a way to power-cycle the system. A long press latches a low-power shutdown request.

One tick-driven counter measures the hold time from the first synchronised high sample. The debounce and hold thresholds are parameters in microseconds, converted to tick counts using the tick period. A long press that expires while an overvoltage or overtemperature fault is active does not shut down. The switches stay off until the level is released. When the pin is configured for a thermistor with its internal pull-up, the whole function is bypassed. Each switch enable is also gated by an external protection disable, so restoring the switches can never override a fault that is still active.

Top module: `host_ctl_timer`

## Requirements
- R1: After reset, shutdown_o is low, and chg_en_o and dsg_en_o are high whenever their block inputs are low.
- R2: A high level on ctl_i that lasts fewer than DEB_T = DEBOUNCE_US/TICK_US counted ticks leaves both enables high for the whole event.
- R3: A high level held for DEB_T ticks drives both chg_en_o and dsg_en_o low. This happens no later than DEB_T+4 clock cycles after ctl_i rises when tick_i is high every cycle.
- R4: If ctl_i falls before HOLD_T = HOLD_US/TICK_US ticks have been counted, both enables return high within 4 clock cycles and shutdown_o stays low.
- R5: If the level stays high for HOLD_T ticks and both ov_flt_i and ot_flt_i are low when the count reaches HOLD_T, shutdown_o goes high. It then stays high until rst_ni, and both enables are low for as long as it is high.
- R6: If ov_flt_i or ot_flt_i is high when the count reaches HOLD_T, shutdown_o stays low. Both enables stay low until ctl_i falls and then return high.
- R7: Every new press starts its count from zero. The time spent in an earlier press or in the fault-held state does not carry over.
- R8: While pullup_mode_i is high and shutdown_o is low, ctl_i is ignored: no override, and no shutdown request.
- R9: The timer advances only on cycles with tick_i high. A high level held with tick_i low never turns the enables off.
- R10: chg_block_i high forces chg_en_o low, and dsg_block_i high forces dsg_en_o low, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable, one pulse per TICK_US |
| ctl_i | input | 1 | Raw host control level, asynchronous, active high |
| ov_flt_i | input | 1 | Overvoltage fault present |
| ot_flt_i | input | 1 | Overtemperature fault present |
| pullup_mode_i | input | 1 | Pin configured for thermistor pull-up; bypasses the function |
| chg_block_i | input | 1 | External protection disable for the charge switch |
| dsg_block_i | input | 1 | External protection disable for the discharge switch |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| shutdown_o | output | 1 | Sticky low-power shutdown request |

## Verification
A corrupted state register shows up at once as a pair of enables with the wrong level, because both enables are decoded directly from the state. Each mismatch is caught at the next sample point after the press or release edge. A counter that fails to clear shows up only on a later press: shutdown asserts during a press shorter than the hold threshold. The bench follows a fault-held expiry with a near-threshold press to expose this. A wrong fault or bypass qualification makes shutdown_o rise on the cycle the count expires, and this is visible within a few cycles of that expiry.

// File: rtl/host_ctl_pkg.sv
package host_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_OFF   = 3'd2,
    ST_LOCK  = 3'd3,
    ST_SHDN  = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hc_hold_timer.sv
module hc_hold_timer #(
  parameter int DEB_T  = 2,
  parameter int HOLD_T = 45000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic deb_o,
  output logic hold_o
);
  localparam int CW = $clog2(HOLD_T + 1);
  localparam logic [CW-1:0] DEB_C  = CW'(DEB_T);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_T);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != HOLD_C) cnt_q <= cnt_q + 1'b1;
  end

  assign deb_o  = (cnt_q >= DEB_C);
  assign hold_o = (cnt_q == HOLD_C);
endmodule

// File: rtl/hc_ctl_fsm.sv
module hc_ctl_fsm
  import host_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic deb_i,
  input  logic hold_i,
  input  logic fault_i,
  input  logic bypass_i,
  output logic run_o,
  output logic force_off_o,
  output logic shdn_o
);
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == ST_SHDN) begin
      st_d = ST_SHDN;
    end else if (bypass_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (lvl_i) st_d = ST_ARMED;
        ST_ARMED: begin
          if (!lvl_i)     st_d = ST_IDLE;
          else if (deb_i) st_d = ST_OFF;
        end
        ST_OFF: begin
          if (!lvl_i)      st_d = ST_IDLE;
          else if (hold_i) st_d = fault_i ? ST_LOCK : ST_SHDN;
        end
        ST_LOCK:  if (!lvl_i) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // counter only runs inside a live press; idle, lockout and shutdown clear it
  assign run_o       = lvl_i && !bypass_i && (st_q == ST_ARMED || st_q == ST_OFF);
  assign force_off_o = (st_q == ST_OFF) || (st_q == ST_LOCK) || (st_q == ST_SHDN);
  assign shdn_o      = (st_q == ST_SHDN);
endmodule

// File: rtl/host_ctl_timer.sv
module host_ctl_timer #(
  parameter int TICK_US     = 100,
  parameter int DEBOUNCE_US = 200,
  parameter int HOLD_US     = 4500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ctl_i,
  input  logic ov_flt_i,
  input  logic ot_flt_i,
  input  logic pullup_mode_i,
  input  logic chg_block_i,
  input  logic dsg_block_i,
  output logic chg_en_o,
  output logic dsg_en_o,
  output logic shutdown_o
);
  localparam int DEB_T  = (DEBOUNCE_US + TICK_US - 1) / TICK_US;
  localparam int HOLD_T = HOLD_US / TICK_US;

  logic lvl, run, deb_hit, hold_hit, force_off, shdn;

  hc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_i),
    .q_o   (lvl)
  );

  hc_hold_timer #(.DEB_T(DEB_T), .HOLD_T(HOLD_T)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick_i),
    .deb_o (deb_hit),
    .hold_o(hold_hit)
  );

  hc_ctl_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .deb_i      (deb_hit),
    .hold_i     (hold_hit),
    .fault_i    (ov_flt_i | ot_flt_i),
    .bypass_i   (pullup_mode_i),
    .run_o      (run),
    .force_off_o(force_off),
    .shdn_o     (shdn)
  );

  assign chg_en_o   = !force_off && !chg_block_i;
  assign dsg_en_o   = !force_off && !dsg_block_i;
  assign shutdown_o = shdn;
endmodule

// File: rtl/host_ctl_timer_chk.sv
module host_ctl_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ov_flt_i,
  input logic ot_flt_i,
  input logic pullup_mode_i,
  input logic chg_block_i,
  input logic dsg_block_i,
  input logic chg_en_o,
  input logic dsg_en_o,
  input logic shutdown_o
);
  p_shdn_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);

  p_shdn_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (!chg_en_o && !dsg_en_o));

  p_fault_no_shdn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(!ov_flt_i && !ot_flt_i));

  p_bypass_no_shdn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pullup_mode_i && !shutdown_o) |=> !shutdown_o);

  p_bypass_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pullup_mode_i && !shutdown_o) |=> (chg_en_o == !chg_block_i));

  p_chg_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_block_i |-> !chg_en_o);

  p_dsg_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsg_block_i |-> !dsg_en_o);
endmodule

bind host_ctl_timer host_ctl_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ov_flt_i     (ov_flt_i),
  .ot_flt_i     (ot_flt_i),
  .pullup_mode_i(pullup_mode_i),
  .chg_block_i  (chg_block_i),
  .dsg_block_i  (dsg_block_i),
  .chg_en_o     (chg_en_o),
  .dsg_en_o     (dsg_en_o),
  .shutdown_o   (shutdown_o)
);

// File: tb/sim_host_ctl_timer.sv
`timescale 1ns/1ps
module sim_host_ctl_timer;
  localparam int TICK_US = 50;
  localparam int DEB_T   = 4;   // 200 / 50
  localparam int HOLD_T  = 90;  // 4500 / 50

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b1, ctl = 1'b0, ov = 1'b0, ot = 1'b0, pu = 1'b0;
  logic cblk = 1'b0, dblk = 1'b0;
  logic chg_en, dsg_en, shdn;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  host_ctl_timer #(.TICK_US(TICK_US), .DEBOUNCE_US(200), .HOLD_US(4500)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .ctl_i(ctl),
    .ov_flt_i(ov), .ot_flt_i(ot), .pullup_mode_i(pu),
    .chg_block_i(cblk), .dsg_block_i(dblk),
    .chg_en_o(chg_en), .dsg_en_o(dsg_en), .shutdown_o(shdn)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {chg,dsg,shdn} got %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset state", {chg_en, dsg_en, shdn}, 3'b110);
  endtask

  task automatic t_glitch;
    logic seen_off = 1'b0;
    ctl = 1'b1;
    for (int i = 0; i < DEB_T - 1; i++) begin
      cyc(1);
      if (!chg_en || !dsg_en) seen_off = 1'b1;
    end
    ctl = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (!chg_en || !dsg_en) seen_off = 1'b1;
    end
    chk("R2 short glitch ignored", {~seen_off, ~seen_off, shdn}, 3'b110);
  endtask

  task automatic t_short_press;
    ctl = 1'b1;
    cyc(DEB_T + 4);
    chk("R3 enables off after debounce", {chg_en, dsg_en, shdn}, 3'b000);
    cyc(HOLD_T - 20);
    chk("R4 still off before hold", {chg_en, dsg_en, shdn}, 3'b000);
    ctl = 1'b0;
    cyc(4);
    chk("R4 restored after release", {chg_en, dsg_en, shdn}, 3'b110);
  endtask

  task automatic t_tick_gate;
    tick = 1'b0;
    ctl  = 1'b1;
    cyc(HOLD_T + 20);
    chk("R9 no count without tick", {chg_en, dsg_en, shdn}, 3'b110);
    tick = 1'b1;
    cyc(DEB_T + 2);
    chk("R9 count resumes with tick", {chg_en, dsg_en, shdn}, 3'b000);
    ctl = 1'b0;
    cyc(4);
    chk("R9 release restores", {chg_en, dsg_en, shdn}, 3'b110);
  endtask

  task automatic t_fault_expiry;
    ov  = 1'b1;
    ctl = 1'b1;
    cyc(HOLD_T + 15);
    chk("R6 ov at expiry: held off, no shutdown", {chg_en, dsg_en, shdn}, 3'b000);
    ov = 1'b0;
    cyc(5);
    chk("R6 still off while held", {chg_en, dsg_en, shdn}, 3'b000);
    ctl = 1'b0;
    cyc(4);
    chk("R6 restored on release", {chg_en, dsg_en, shdn}, 3'b110);
    ctl = 1'b1;
    cyc(HOLD_T - 8);
    chk("R7 fresh count after lockout", {chg_en, dsg_en, shdn}, 3'b000);
    ctl = 1'b0;
    cyc(4);
    chk("R7 release after fresh press", {chg_en, dsg_en, shdn}, 3'b110);
    ot  = 1'b1;
    ctl = 1'b1;
    cyc(HOLD_T + 15);
    chk("R6 ot at expiry blocks shutdown", {chg_en, dsg_en, shdn}, 3'b000);
    ctl = 1'b0;
    ot  = 1'b0;
    cyc(4);
    chk("R6 restored after ot press", {chg_en, dsg_en, shdn}, 3'b110);
  endtask

  task automatic t_block;
    cblk = 1'b1;
    cyc(1);
    chk("R10 charge block", {chg_en, dsg_en, shdn}, 3'b010);
    ctl = 1'b1;
    cyc(DEB_T + 6);
    ctl = 1'b0;
    cyc(4);
    chk("R10 release does not override charge block", {chg_en, dsg_en, shdn}, 3'b010);
    cblk = 1'b0;
    dblk = 1'b1;
    cyc(1);
    chk("R10 discharge block", {chg_en, dsg_en, shdn}, 3'b100);
    dblk = 1'b0;
    cyc(1);
  endtask

  task automatic t_bypass;
    pu  = 1'b1;
    ctl = 1'b1;
    cyc(DEB_T + 6);
    chk("R8 no override in pull-up mode", {chg_en, dsg_en, shdn}, 3'b110);
    cyc(HOLD_T + 10);
    chk("R8 no shutdown in pull-up mode", {chg_en, dsg_en, shdn}, 3'b110);
    ctl = 1'b0;
    pu  = 1'b0;
    cyc(4);
  endtask

  task automatic t_shutdown;
    ctl = 1'b1;
    cyc(HOLD_T + 10);
    chk("R5 long hold shuts down", {chg_en, dsg_en, shdn}, 3'b001);
    ctl = 1'b0;
    pu  = 1'b1;
    cyc(10);
    chk("R5 shutdown sticky after release", {chg_en, dsg_en, shdn}, 3'b001);
    pu = 1'b0;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
    chk("R5 reset clears shutdown", {chg_en, dsg_en, shdn}, 3'b110);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_glitch();
    t_short_press();
    t_tick_gate();
    t_fault_expiry();
    t_block();
    t_bypass();
    t_shutdown();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule